// File: doc/BRIEF.md
# Flash Address Range Write/Read Guard

This block sits inside a serial flash controller and screens every direct flash access before it reaches the serial engine. Software programs up to five protected windows through a small register port. Each window has a start page, an end page, and separate enables for blocking writes and blocking reads. Pages are 4 KB. When an access request arrives, the block compares its address with every window. It then answers with either a grant or a block. The check uses no processor privilege or mode input, so the same rule applies to every requester.

A one-shot freeze bit in the status register makes all window registers permanently read-only until the next reset, which stops later code from reopening protected flash. Any blocked request raises a sticky error flag. Software clears the flag by writing a one to it.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, every window register reads 0, the status register reads 0, and every access is granted.
- R2: Window i (i = 0..4) lives at register offset 0x74 + 4*i. Its fields are: start page in bits 12:0, read-block enable in bit 15, end page in bits 28:16, and write-block enable in bit 31. The other bits are written as don't-care and read back as 0. Reads return data one cycle after the offset is presented.
- R3: A write request is blocked when some window has its write-block enable set and the window covers the address. The start byte is start page * 4096 and the end byte is end page * 4096 + 4095, both inclusive.
- R4: A read request is blocked when a covering window has its read-block enable set. The write-block enable has no effect on reads, and the read-block enable has no effect on writes.
- R5: The end page is covered in full. For the value 0x87FF0780, address 0x7FFFFF is write-blocked, and the addresses 0x77FFFF and 0x800000 are granted.
- R6: A window whose end page is below its start page covers no address.
- R7: A match in any single window, including the last one, is enough to block. An address that no enabled window covers is granted.
- R8: For a request presented on a cycle, exactly one of grant and block is high after the next clock edge. Both are low after a cycle with no request.
- R9: The status register sits at offset 0x04. Its bit 15 is the freeze bit. Writing 1 sets it, writing 0 has no effect, and only reset clears it.
- R10: While the freeze bit is set, writes to window registers are ignored. Read-back and checking keep using the old values.
- R11: Status bit 0 is the error flag. It sets on the same edge as any block output and stays set until software writes 1 to bit 0. If a block and a clear happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for last cycle's offset |
| acc_valid | input | 1 | Flash access request present |
| acc_write | input | 1 | 1 = write or erase, 0 = read |
| acc_addr | input | 25 | Flash byte address |
| acc_grant | output | 1 | Request allowed (registered) |
| acc_block | output | 1 | Request refused (registered) |
| err_flag | output | 1 | Sticky blocked-access flag |

## Verification
Grant, block and the error flag are all due one clock edge after the request cycle. Register read data is due one edge after the offset is presented. A register write affects a request presented on the cycle after the write. The bench drives every input on a falling edge and samples the results on the following falling edge, which is exactly one rising edge later. A write and a request that overlap are issued in separate cycles, except for the single cycle that deliberately tests a block and a clear together.

// File: rtl/frg_pkg.sv
package frg_pkg;
  localparam int FLD_W    = 13;
  localparam int BASE_LSB = 0;
  localparam int LIM_LSB  = 16;
  localparam int RP_BIT   = 15;
  localparam int WP_BIT   = 31;
  localparam int LOCK_BIT = 15;
  localparam int ERR_BIT  = 0;

  typedef struct packed {
    logic             wp;
    logic [FLD_W-1:0] lim;
    logic             rp;
    logic [FLD_W-1:0] base;
  } rng_t;

  localparam int RNG_W = $bits(rng_t);

  function automatic rng_t img_to_rng(input logic [31:0] d);
    rng_t r;
    r.wp   = d[WP_BIT];
    r.lim  = d[LIM_LSB +: FLD_W];
    r.rp   = d[RP_BIT];
    r.base = d[BASE_LSB +: FLD_W];
    return r;
  endfunction

  function automatic logic [31:0] rng_to_img(input rng_t r);
    logic [31:0] d;
    d = '0;
    d[WP_BIT]              = r.wp;
    d[LIM_LSB +: FLD_W]    = r.lim;
    d[RP_BIT]              = r.rp;
    d[BASE_LSB +: FLD_W]   = r.base;
    return d;
  endfunction
endpackage

// File: rtl/frg_regs.sv
module frg_regs import frg_pkg::*; #(
  parameter int NUM_RNG  = 5,
  parameter int REG_AW   = 8,
  parameter int RNG_OFS  = 'h74,
  parameter int STAT_OFS = 'h04
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [REG_AW-1:0]        addr,
  input  logic [31:0]              wdata,
  input  logic                     err_set,
  output rng_t [NUM_RNG-1:0]       rng,
  output logic                     locked,
  output logic                     err,
  output logic [31:0]              rdata
);
  localparam logic [REG_AW-1:0] STAT_A = REG_AW'(STAT_OFS);

  logic stat_wr;
  assign stat_wr = wr_en && (addr == STAT_A);

  // freeze bit: set-only, cleared by reset
  always_ff @(posedge clk) begin
    if (rst)                             locked <= 1'b0;
    else if (stat_wr && wdata[LOCK_BIT]) locked <= 1'b1;
  end

  // sticky error: a new block wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)                                 err <= 1'b0;
    else if (err_set)                        err <= 1'b1;
    else if (stat_wr && wdata[ERR_BIT])      err <= 1'b0;
  end

  for (genvar i = 0; i < NUM_RNG; i++) begin : g_rng
    localparam logic [REG_AW-1:0] MY_A = REG_AW'(RNG_OFS + 4*i);
    always_ff @(posedge clk) begin
      if (rst)                                  rng[i] <= '0;
      else if (wr_en && addr == MY_A && !locked) rng[i] <= img_to_rng(wdata);
    end
  end

  logic [31:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    if (addr == STAT_A) begin
      rd_nxt[LOCK_BIT] = locked;
      rd_nxt[ERR_BIT]  = err;
    end
    for (int i = 0; i < NUM_RNG; i++) begin
      if (addr == REG_AW'(RNG_OFS + 4*i)) rd_nxt = rng_to_img(rng[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/frg_match.sv
module frg_match import frg_pkg::*; #(
  parameter int NUM_RNG = 5,
  parameter int PAGE_W  = 12
) (
  input  rng_t [NUM_RNG-1:0]        rng,
  input  logic [FLD_W+PAGE_W-1:0]   addr,
  input  logic                      is_wr,
  output logic                      hit
);
  localparam int ADDR_W = FLD_W + PAGE_W;

  logic [NUM_RNG-1:0] in_rng;

  for (genvar i = 0; i < NUM_RNG; i++) begin : g_cmp
    logic [ADDR_W-1:0] lo, hi;
    logic              en;
    assign lo = {rng[i].base, {PAGE_W{1'b0}}};
    assign hi = {rng[i].lim,  {PAGE_W{1'b1}}};
    assign en = is_wr ? rng[i].wp : rng[i].rp;
    // an inverted window fails one of the two compares and never matches
    assign in_rng[i] = en && (addr >= lo) && (addr <= hi);
  end

  assign hit = |in_rng;
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard import frg_pkg::*; #(
  parameter int NUM_RNG  = 5,
  parameter int PAGE_W   = 12,
  parameter int REG_AW   = 8,
  parameter int RNG_OFS  = 'h74,
  parameter int STAT_OFS = 'h04
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr_en,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [FLD_W+PAGE_W-1:0] acc_addr,
  output logic                    acc_grant,
  output logic                    acc_block,
  output logic                    err_flag
);
  rng_t [NUM_RNG-1:0] rng_q;
  logic               lock_q;
  logic               hit;
  logic               blk_now;

  assign blk_now = acc_valid && hit;

  frg_regs #(
    .NUM_RNG(NUM_RNG), .REG_AW(REG_AW), .RNG_OFS(RNG_OFS), .STAT_OFS(STAT_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .err_set(blk_now), .rng(rng_q), .locked(lock_q), .err(err_flag), .rdata(reg_rdata)
  );

  frg_match #(.NUM_RNG(NUM_RNG), .PAGE_W(PAGE_W)) u_match (
    .rng(rng_q), .addr(acc_addr), .is_wr(acc_write), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_grant <= 1'b0;
      acc_block <= 1'b0;
    end else begin
      acc_grant <= acc_valid && !hit;
      acc_block <= blk_now;
    end
  end
endmodule

// File: rtl/frg_checker.sv
module frg_checker #(
  parameter int FLAT_W = 140
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_grant,
  input logic              acc_block,
  input logic              err_flag,
  input logic              locked,
  input logic [FLAT_W-1:0] rng_flat
);
  assert_one_answer_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> ($countones({acc_grant, acc_block}) == 1));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!acc_grant && !acc_block));

  assert_freeze_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  assert_frozen_ranges_R10: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(rng_flat));

  assert_block_sets_err_R11: assert property (@(posedge clk) disable iff (rst)
    acc_block |-> err_flag);
endmodule

bind flash_range_guard frg_checker #(.FLAT_W(NUM_RNG * frg_pkg::RNG_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_grant(acc_grant),
  .acc_block(acc_block), .err_flag(err_flag), .locked(lock_q), .rng_flat(rng_q)
);

// File: tb/flash_range_guard_tb.sv
`timescale 1ns/1ps
module flash_range_guard_tb;
  localparam logic [31:0] MASK = 32'h9FFF9FFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [24:0] acc_addr = '0;
  logic        acc_grant, acc_block, err_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_img [5];
  bit          m_lock, m_err;

  always #2.5 clk = ~clk;

  flash_range_guard u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_grant(acc_grant),
    .acc_block(acc_block), .err_flag(err_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [24:0] a, input bit w);
    for (int i = 0; i < 5; i++) begin
      bit en = w ? m_img[i][31] : m_img[i][15];
      if (en && a[24:12] >= m_img[i][12:0] && a[24:12] <= m_img[i][28:16]) return 1;
    end
    return 0;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) m_img[i] = '0;
    m_lock = 0;
    m_err = 0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 8'h04) begin
      if (d[0])  m_err = 0;
      if (d[15]) m_lock = 1;
    end else if (!m_lock && a >= 8'h74 && a <= 8'h84 && a[1:0] == 2'b00) begin
      m_img[(a - 8'h74) >> 2] = d & MASK;
    end
  endtask

  task automatic reg_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic acc(input string req, input logic [24:0] a, input bit w);
    bit b;
    b = exp_hit(a, w);
    acc_valid = 1'b1; acc_write = w; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    if (b) m_err = 1;
    check(req, {29'b0, acc_grant, acc_block, err_flag}, {29'b0, !b, b, m_err});
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R1: reset state
    for (int i = 0; i < 5; i++) reg_chk("R1", 8'(8'h74 + 4*i), 32'h0);
    reg_chk("R1", 8'h04, 32'h0);
    acc("R1", 25'h0000000, 1'b1);
    acc("R1", 25'h1FFFFFF, 1'b0);

    // R8: idle cycle gives neither answer
    @(negedge clk);
    check("R8", {30'b0, acc_grant, acc_block}, 32'h0);

    // R2: layout and reserved bits
    reg_wr(8'h74, 32'h87FF0780);
    reg_chk("R2", 8'h74, 32'h87FF0780);
    reg_wr(8'h78, 32'hFFFFFFFF);
    reg_chk("R2", 8'h78, 32'h9FFF9FFF);
    reg_wr(8'h78, 32'h0);
    reg_chk("R2", 8'h78, 32'h0);

    // R3 / R5: write-protected window 0x780000..0x7FFFFF
    acc("R3", 25'h0780000, 1'b1);
    acc("R5", 25'h07FFFFF, 1'b1);
    acc("R5", 25'h077FFFF, 1'b1);
    acc("R5", 25'h0800000, 1'b1);
    acc("R4", 25'h07A0000, 1'b0);

    // R11: clear, then block and clear in the same cycle
    reg_chk("R11", 8'h04, 32'h1);
    reg_wr(8'h04, 32'h0);
    reg_chk("R11", 8'h04, 32'h1);
    reg_wr(8'h04, 32'h1);
    reg_chk("R11", 8'h04, 32'h0);
    reg_wr_en = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h1;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 25'h07C0000;
    @(negedge clk);
    reg_wr_en = 1'b0; acc_valid = 1'b0;
    m_err = 1;
    check("R11", {31'b0, err_flag}, 32'h1);
    reg_wr(8'h04, 32'h1);
    check("R11", {31'b0, err_flag}, 32'h0);

    // R4: read-only protection on page 0x010
    reg_wr(8'h78, 32'h00108010);
    acc("R4", 25'h0010800, 1'b0);
    acc("R4", 25'h0010800, 1'b1);

    // R6: inverted window never matches
    reg_wr(8'h7C, 32'h80FF8100);
    acc("R6", 25'h0100000, 1'b1);
    acc("R6", 25'h00FF000, 1'b0);

    // R7: last window alone blocks
    reg_wr(8'h84, 32'h9AAA9AAA);
    acc("R7", 25'h1AAA123, 1'b1);
    acc("R7", 25'h1AAA123, 1'b0);
    acc("R7", 25'h1AAB000, 1'b1);
    reg_wr(8'h04, 32'h1);

    // random mix, R3 R4 R7 R8
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 4) == 0) begin
        logic [12:0] bs;
        logic [12:0] lm;
        logic [31:0] d;
        bs = 13'($urandom_range(0, 8191));
        lm = bs + 13'($urandom_range(0, 40));
        d = $urandom;
        d[12:0] = bs; d[28:16] = lm;
        reg_wr(8'(8'h74 + 4*$urandom_range(0, 4)), d);
      end else begin
        int r;
        logic [12:0] pg;
        logic [24:0] a;
        r = $urandom_range(0, 4);
        case ($urandom_range(0, 4))
          0: pg = m_img[r][12:0] - 13'd1;
          1: pg = m_img[r][12:0];
          2: pg = m_img[r][28:16];
          3: pg = m_img[r][28:16] + 13'd1;
          default: pg = 13'($urandom);
        endcase
        a = {pg, 12'($urandom)};
        if ($urandom_range(0, 1) == 1) a[11:0] = $urandom_range(0, 1) == 1 ? 12'hFFF : 12'h000;
        acc("R3", a, 1'($urandom_range(0, 1)));
      end
    end

    // R9 / R10: freeze
    reg_wr(8'h74, 32'h87FF0780);
    reg_wr(8'h04, 32'h00008001);
    reg_chk("R9", 8'h04, 32'h00008000);
    reg_wr(8'h04, 32'h0);
    reg_chk("R9", 8'h04, 32'h00008000);
    reg_wr(8'h74, 32'h0);
    reg_chk("R10", 8'h74, 32'h87FF0780);
    acc("R10", 25'h07FF000, 1'b1);
    reg_wr(8'h84, 32'h0);
    acc("R10", 25'h1AAA000, 1'b1);

    // R9: reset clears the freeze
    do_reset();
    reg_chk("R9", 8'h04, 32'h0);
    reg_wr(8'h74, 32'h80010001);
    reg_chk("R9", 8'h74, 32'h80010001);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule